// File: doc/BRIEF.md
# Pin Bank Controller with Four-Way Function Select

This block governs a bank of 32 pads. Each pad is either kept by the controller as a general-purpose pin or handed to one of four peripheral functions. For each pin the controller holds its own output enable, output level, pull-up, pull-down, open-drain mode, input filter enable and filter mode. The pad side sees a drive value, a drive enable and pull controls. The pin level comes back through a two-stage synchronizer.

Software changes each attribute through a pair of write-only strobes. Writing a 1 to the set address turns the matching bits on. Writing a 1 to the clear address turns them off. A zero bit leaves its pin alone. A third address returns the current state. The function select codes, the Schmitt-disable mask and the debounce divider field are plain read/write words. The bus is a single-cycle register port: writes land on the clock edge, and read data is combinational from the address.

Top module: `pmx_bank`

## Requirements
- R1: After reset every pin is owned by the controller, output drive is off, output level is 0, pull-up is on, pull-down, open-drain and filter are off, all plain registers are 0.
- R2: For each attribute, a write to its set address ORs the data into the state; a write to its clear address removes the written 1 bits; bits written as 0 keep their value.
- R3: Attribute g (ownership 0, drive enable 1, output level 2, pull-up 3, open-drain 4, filter enable 5, pull-down 6, filter mode 7) sits at word address 4g (set), 4g+1 (clear), 4g+2 (state); 4g+3 and any address at or above 0x25 read 0.
- R4: The pull-up state word reads inverted: a 0 bit means the pull-up of that pin is on, while pad_pu_o is 1 for an enabled pull-up.
- R5: A pin released by the controller takes drive value and enable from function {sel2[n], sel1[n]}: 00 first, 01 second (sel1 set), 10 third (sel2 set), 11 fourth; sel1 is at 0x20 and sel2 at 0x21. The function ports are flattened with function f for pin n at bit 32f+n.
- R6: Address 0x24 returns the pin levels two clock edges after pad_in_i changes, whether or not the controller owns the pin.
- R7: With open-drain on, the pad is driven only when the wanted value is 0: pad_oe_o is the enable AND NOT the value, and pad_out_o is 0.
- R8: Set and clear addresses always read 0.
- R9: Filter enable and filter mode state drive filt_en_o and filt_deb_o, where a set mode bit selects debounce and a cleared bit selects glitch. The divider at 0x23 keeps its low 14 bits on filt_div_o and reads back zero-extended.
- R10: The Schmitt-disable word at 0x22 is plain read/write and drives pad_st_dis_o, where a 1 disables the trigger.
- R11: On a controller-owned pin without open-drain, pad_oe_o follows the drive-enable state and pad_out_o follows the output-level state.
- R12: The pull-down state drives pad_pd_o directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| per_oe_i | input | 128 | Function drive enables, function f pin n at 32f+n |
| per_out_i | input | 128 | Function drive values, same layout |
| pad_in_i | input | 32 | Raw pad levels |
| pad_oe_o | output | 32 | Pad drive enable |
| pad_out_o | output | 32 | Pad drive value |
| pad_pu_o | output | 32 | Pull-up enable |
| pad_pd_o | output | 32 | Pull-down enable |
| pad_st_dis_o | output | 32 | Schmitt-trigger disable |
| filt_en_o | output | 32 | Input filter enable |
| filt_deb_o | output | 32 | Filter mode, 1 is debounce |
| filt_div_o | output | 14 | Debounce divider field |
| pin_level_o | output | 32 | Synchronized pin levels |

## Verification
The hardest case to reach is one where ownership, function code and open-drain all decide a single pad in the same cycle. A selection fault only shows when the four functions present different values on the same pin. The stimulus therefore gives each function a one-hot value pattern. Four adjacent pins are released with all four codes at once, so only a correct selection yields a full nibble. The code words are then rewritten to give a second, distinct pattern. Open-drain is exercised on pins whose drive enable is on, with one level high and one level low, so both the float and the drive-low outcome are seen.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int ADDR_W   = 6;
  localparam int NUM_GRP  = 8;
  localparam int NUM_FUNC = 4;

  typedef enum logic [2:0] {
    GRP_OWN, GRP_OE, GRP_DATA, GRP_PU, GRP_MD, GRP_FLT, GRP_PD, GRP_FMODE
  } grp_e;

  localparam logic [1:0] SUB_SET  = 2'd0;
  localparam logic [1:0] SUB_CLR  = 2'd1;
  localparam logic [1:0] SUB_STAT = 2'd2;

  localparam logic [ADDR_W-1:0] A_SEL1  = 6'h20;
  localparam logic [ADDR_W-1:0] A_SEL2  = 6'h21;
  localparam logic [ADDR_W-1:0] A_STDIS = 6'h22;
  localparam logic [ADDR_W-1:0] A_DIV   = 6'h23;
  localparam logic [ADDR_W-1:0] A_LEVEL = 6'h24;
endpackage

// File: rtl/pmx_setclr.sv
module pmx_setclr #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_VAL;
    else if (set_i) q_o <= q_o | wdata_i;
    else if (clr_i) q_o <= q_o & ~wdata_i;
  end

  AST_SET_ORS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(wdata_i)) == $past(wdata_i))); // R2
  AST_CLR_ANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((q_o & $past(wdata_i)) == '0)); // R2
  AST_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i || clr_i) |=> ((q_o & ~$past(wdata_i)) == ($past(q_o) & ~$past(wdata_i)))); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o)); // R2
endmodule

// File: rtl/pmx_sync.sv
module pmx_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

  // counts edges since reset so the latency check never looks before it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= 2'd0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  AST_SYNC_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (q_o == $past(d_i, 2))); // R6
endmodule

// File: rtl/pmx_pad_path.sv
module pmx_pad_path import pmx_pkg::*; #(
  parameter int PINS = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [PINS-1:0]          own_i,
  input  logic [PINS-1:0]          oe_i,
  input  logic [PINS-1:0]          dat_i,
  input  logic [PINS-1:0]          md_i,
  input  logic [PINS-1:0]          sel1_i,
  input  logic [PINS-1:0]          sel2_i,
  input  logic [NUM_FUNC*PINS-1:0] per_oe_i,
  input  logic [NUM_FUNC*PINS-1:0] per_out_i,
  output logic [PINS-1:0]          pad_oe_o,
  output logic [PINS-1:0]          pad_out_o
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [NUM_FUNC-1:0] oe_opt, out_opt;
    logic [1:0]          fsel;
    logic                want_oe, want_val;

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
      assign oe_opt[f]  = per_oe_i[f*PINS + p];
      assign out_opt[f] = per_out_i[f*PINS + p];
    end

    assign fsel     = {sel2_i[p], sel1_i[p]};
    assign want_oe  = own_i[p] ? oe_i[p]  : oe_opt[fsel];
    assign want_val = own_i[p] ? dat_i[p] : out_opt[fsel];

    // open-drain: drive only a low level
    assign pad_oe_o[p]  = md_i[p] ? (want_oe & ~want_val) : want_oe;
    assign pad_out_o[p] = md_i[p] ? 1'b0 : want_val;

    AST_OD_FLOAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own_i[p] && md_i[p] && dat_i[p]) |-> !pad_oe_o[p]); // R7
    AST_OWN_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own_i[p] && !md_i[p]) |-> (pad_oe_o[p] == oe_i[p] && pad_out_o[p] == dat_i[p])); // R11
  end
endmodule

// File: rtl/pmx_bank.sv
module pmx_bank import pmx_pkg::*; #(
  parameter int PINS  = 32,
  parameter int DIV_W = 14
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_we_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [PINS-1:0]          bus_wdata_i,
  output logic [PINS-1:0]          bus_rdata_o,
  input  logic [NUM_FUNC*PINS-1:0] per_oe_i,
  input  logic [NUM_FUNC*PINS-1:0] per_out_i,
  input  logic [PINS-1:0]          pad_in_i,
  output logic [PINS-1:0]          pad_oe_o,
  output logic [PINS-1:0]          pad_out_o,
  output logic [PINS-1:0]          pad_pu_o,
  output logic [PINS-1:0]          pad_pd_o,
  output logic [PINS-1:0]          pad_st_dis_o,
  output logic [PINS-1:0]          filt_en_o,
  output logic [PINS-1:0]          filt_deb_o,
  output logic [DIV_W-1:0]         filt_div_o,
  output logic [PINS-1:0]          pin_level_o
);
  logic              in_grp;
  logic [2:0]        grp;
  logic [1:0]        sub;
  logic [NUM_GRP-1:0] set_v, clr_v;
  logic [PINS-1:0]   grp_q [NUM_GRP];
  logic [PINS-1:0]   sel1_q, sel2_q, stdis_q, lvl;
  logic [DIV_W-1:0]  div_q;

  assign in_grp = ~bus_addr_i[ADDR_W-1];
  assign grp    = bus_addr_i[4:2];
  assign sub    = bus_addr_i[1:0];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_attr
    localparam logic [PINS-1:0] RV =
      (g == int'(GRP_OWN) || g == int'(GRP_PU)) ? {PINS{1'b1}} : {PINS{1'b0}};
    assign set_v[g] = bus_we_i & in_grp & (grp == 3'(g)) & (sub == SUB_SET);
    assign clr_v[g] = bus_we_i & in_grp & (grp == 3'(g)) & (sub == SUB_CLR);
    pmx_setclr #(.W(PINS), .RST_VAL(RV)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_v[g]),
      .clr_i   (clr_v[g]),
      .wdata_i (bus_wdata_i),
      .q_o     (grp_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel1_q  <= '0;
      sel2_q  <= '0;
      stdis_q <= '0;
      div_q   <= '0;
    end else if (bus_we_i) begin
      case (bus_addr_i)
        A_SEL1:  sel1_q  <= bus_wdata_i;
        A_SEL2:  sel2_q  <= bus_wdata_i;
        A_STDIS: stdis_q <= bus_wdata_i;
        A_DIV:   div_q   <= bus_wdata_i[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  pmx_sync #(.W(PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (lvl)
  );

  pmx_pad_path #(.PINS(PINS)) u_pad (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .own_i     (grp_q[GRP_OWN]),
    .oe_i      (grp_q[GRP_OE]),
    .dat_i     (grp_q[GRP_DATA]),
    .md_i      (grp_q[GRP_MD]),
    .sel1_i    (sel1_q),
    .sel2_i    (sel2_q),
    .per_oe_i  (per_oe_i),
    .per_out_i (per_out_i),
    .pad_oe_o  (pad_oe_o),
    .pad_out_o (pad_out_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (in_grp) begin
      if (sub == SUB_STAT)
        bus_rdata_o = (grp == GRP_PU) ? ~grp_q[GRP_PU] : grp_q[grp];
    end else begin
      case (bus_addr_i)
        A_SEL1:  bus_rdata_o = sel1_q;
        A_SEL2:  bus_rdata_o = sel2_q;
        A_STDIS: bus_rdata_o = stdis_q;
        A_DIV:   bus_rdata_o = PINS'(div_q);
        A_LEVEL: bus_rdata_o = lvl;
        default: bus_rdata_o = '0;
      endcase
    end
  end

  assign pad_pu_o     = grp_q[GRP_PU];
  assign pad_pd_o     = grp_q[GRP_PD];
  assign filt_en_o    = grp_q[GRP_FLT];
  assign filt_deb_o   = grp_q[GRP_FMODE];
  assign filt_div_o   = div_q;
  assign pad_st_dis_o = stdis_q;
  assign pin_level_o  = lvl;

  AST_STROBE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_grp && (sub == SUB_SET || sub == SUB_CLR)) |-> (bus_rdata_o == '0)); // R8
  AST_PU_READ_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_grp && grp == GRP_PU && sub == SUB_STAT) |-> (bus_rdata_o == ~pad_pu_o)); // R4
  AST_LEVEL_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == A_LEVEL) |-> (bus_rdata_o == pin_level_o)); // R6
endmodule

// File: tb/tb_pmx_bank.sv
module tb_pmx_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [5:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [127:0] per_oe  = '1;
  logic [127:0] per_out = {32'h0008_0000, 32'h0004_0000, 32'h0002_0000, 32'h0001_0000};
  logic [31:0]  pad_in = '0;
  logic [31:0]  pad_oe, pad_out, pad_pu, pad_pd, st_dis, f_en, f_deb, lvl;
  logic [13:0]  f_div;

  always #10 clk = ~clk;

  pmx_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .per_oe_i(per_oe),
    .per_out_i(per_out), .pad_in_i(pad_in), .pad_oe_o(pad_oe),
    .pad_out_o(pad_out), .pad_pu_o(pad_pu), .pad_pd_o(pad_pd),
    .pad_st_dis_o(st_dis), .filt_en_o(f_en), .filt_deb_o(f_deb),
    .filt_div_o(f_div), .pin_level_o(lvl)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [31:0] pick(int kind);
    case (kind)
      0: return rdata;
      1: return pad_oe;
      2: return pad_out;
      3: return pad_pu;
      4: return pad_pd;
      5: return f_en;
      6: return f_deb;
      7: return st_dis;
      default: return {18'b0, f_div};
    endcase
  endfunction

  // monitor: compares queued expectations after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = pick(it.kind);
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind %0d actual %h expected %h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk(input int kind, input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    #6;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(0, 6'h02, 32'hFFFF_FFFF, "R1 own state");
    chk(0, 6'h0E, 32'h0,         "R1 pull-up state");
    chk(3, 6'h00, 32'hFFFF_FFFF, "R1 pad_pu");
    chk(1, 6'h00, 32'h0,         "R1 pad_oe");
    chk(4, 6'h00, 32'h0,         "R1 pad_pd");
    chk(0, 6'h20, 32'h0,         "R1 sel1");

    // R2 set/clear semantics
    wr(6'h04, 32'h0F0);
    wr(6'h04, 32'hF00);
    wr(6'h05, 32'h030);
    chk(0, 6'h06, 32'hFC0, "R2 oe set/clear");
    wr(6'h04, 32'h0);
    wr(6'h05, 32'h0);
    chk(0, 6'h06, 32'hFC0, "R2 zero write keeps");

    // R11 controller-owned drive
    wr(6'h08, 32'hA0A0);
    chk(0, 6'h0A, 32'hA0A0, "R11 data state");
    chk(1, 6'h00, 32'hFC0,  "R11 pad_oe");
    chk(2, 6'h00, 32'hA0A0, "R11 pad_out");

    // R8 / R3 read-zero addresses
    chk(0, 6'h04, 32'h0, "R8 set addr reads 0");
    chk(0, 6'h09, 32'h0, "R8 clear addr reads 0");
    chk(0, 6'h03, 32'h0, "R3 slot 3 reads 0");
    chk(0, 6'h30, 32'h0, "R3 high addr reads 0");

    // R4 pull-up inverted state
    wr(6'h0D, 32'hF);
    chk(0, 6'h0E, 32'hF,         "R4 pull-up state");
    chk(3, 6'h00, 32'hFFFF_FFF0, "R4 pad_pu");

    // R7 open-drain on pins 6 (low) and 7 (high)
    wr(6'h10, 32'hC0);
    chk(0, 6'h12, 32'hC0,   "R7 md state");
    chk(1, 6'h00, 32'hF40,  "R7 pad_oe");
    chk(2, 6'h00, 32'hA020, "R7 pad_out");

    // R5 function select, pins 16..19 released with codes 00,01,10,11
    wr(6'h01, 32'h000F_0000);
    wr(6'h20, 32'h000A_0000);
    wr(6'h21, 32'h000C_0000);
    chk(0, 6'h02, 32'hFFF0_FFFF, "R5 own state");
    chk(0, 6'h20, 32'h000A_0000, "R5 sel1 readback");
    chk(2, 6'h00, 32'h000F_A020, "R5 pad_out all codes");
    chk(1, 6'h00, 32'h000F_0F40, "R5 pad_oe released");
    wr(6'h20, 32'h0);
    chk(2, 6'h00, 32'h0005_A020, "R5 pad_out second pattern");

    // R6 synchronizer latency
    begin
      item_t it;
      @(negedge clk);
      pad_in = 32'h1234_5678;
      addr = 6'h24;
      it.kind = 0; it.exp = 32'h0; it.tag = "R6 level after one edge";
      q.push_back(it);
      @(posedge clk);
      #6;
    end
    chk(0, 6'h24, 32'h1234_5678, "R6 level after two edges");

    // R9 filter
    wr(6'h14, 32'h3);
    wr(6'h1C, 32'h2);
    chk(5, 6'h00, 32'h3, "R9 filt_en");
    chk(6, 6'h00, 32'h2, "R9 filt_deb");
    chk(0, 6'h1E, 32'h2, "R9 mode state");
    wr(6'h1D, 32'h2);
    chk(6, 6'h00, 32'h0, "R9 mode cleared");
    wr(6'h23, 32'hFFFF_FFFF);
    chk(0, 6'h23, 32'h3FFF, "R9 divider readback");
    chk(8, 6'h00, 32'h3FFF, "R9 filt_div");

    // R10 Schmitt disable
    wr(6'h22, 32'h5A);
    chk(0, 6'h22, 32'h5A, "R10 readback");
    chk(7, 6'h00, 32'h5A, "R10 pad_st_dis");

    // R12 pull-down
    wr(6'h18, 32'h100);
    chk(4, 6'h00, 32'h100, "R12 pad_pd");
    chk(0, 6'h1A, 32'h100, "R12 state");
    wr(6'h19, 32'h100);
    chk(4, 6'h00, 32'h0,   "R12 pad_pd cleared");

    repeat (2) @(posedge clk);
    done = 1;
    finish_run();
  end
endmodule